// File: doc/BRIEF.md
# Dual-Standard FSK Tone Modulator

This block is the transmit half of a 300 bps full-duplex frequency-shift-keyed modem, built entirely in logic. It runs from a 3.579545 MHz master clock and produces a signed sine sample once per sample period, together with a one-cycle strobe. The strobe marks when a digital-to-analog stage downstream should take the sample.

Four inputs control it:
- A serial data bit: high sends the mark tone, low sends the space tone.
- An originate/answer select.
- A selector between two common 300 bps tone plans.
- An active-low transmit enable.

The data bit needs no bit clock. Its level is sampled on each sample strobe, so any rate from 0 to 300 bps works.

All eight tones come from one phase accumulator. A change of data bit, mode or plan alters only the accumulator's step size, so the carrier never jumps in phase. When the enable is released, the amplitude falls gradually to zero instead of cutting off abruptly.

Top module: `fsk_tone_gen`

## Requirements
- R1: `sample_stb` pulses high for exactly one clock cycle once every `SAMPLE_DIV` (default 466) clock cycles, giving about 7681 samples per second.
- R2: The tone is selected by the index {`bell_sel`, `orig_sel`, `tx_data`}. With `bell_sel`=0 the tones are: originate mark 980 Hz, originate space 1180 Hz, answer mark 1650 Hz, answer space 1850 Hz. With `bell_sel`=1 they are: originate mark 1270 Hz, originate space 1070 Hz, answer mark 2225 Hz, answer space 2025 Hz. The 24-bit phase step equals the nearest integer to f·2^24·`SAMPLE_DIV`/`CLK_HZ`, which keeps every tone within 6 Hz of nominal.
- R3: `orig_sel` high selects the originate tones and `orig_sel` low selects the answer tones.
- R4: Let k be the top 8 bits of the 24-bit phase and g the gain (0..64). Each sample equals sign(s)·floor(round(2047·|s|)·g/64), where s = sin(2π(k+0.5)/256).
- R5: On every strobe the phase advances by the step of the current tone. A change of tone alters only the step and never reloads the phase. Between strobes the phase does not move.
- R6: While `tx_en_n` is high and the gain has reached 0, every sample is 0 and the phase is held at 0. The next burst therefore starts from zero phase.
- R7: After `tx_en_n` goes high, the gain falls by one per sample, from 64 to 0. The carrier fades over 64 samples, about 8.3 ms, and keeps its current tone while it fades.
- R8: While `tx_en_n` is low, every strobe loads the full gain of 64. This also applies when transmission resumes partway through a fade. Each input takes effect at the first strobe that comes at least 3 clock cycles after the input changes.
- R9: While `rst_n` is low, `sample` is 0 and `sample_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 3.579545 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 1 | Serial data bit, 1 = mark, 0 = space |
| orig_sel | input | 1 | 1 = originate tones, 0 = answer tones |
| bell_sel | input | 1 | 0 = first tone plan, 1 = second tone plan |
| tx_en_n | input | 1 | Active-low transmit enable |
| sample | output | 12 | Signed carrier sample |
| sample_stb | output | 1 | One-cycle strobe marking a new sample |

## Verification
The inputs pass through a two-stage synchronizer, so each sample reflects input values that settled at least 3 cycles before its strobe. The sample register and the strobe update on the same edge, which means a sample is due in the cycle its strobe is high.

The bench changes inputs only on the falling edge that follows a strobe. That leaves about 465 cycles before the next strobe, so every change lands on a known sample. The bench then waits for each strobe and compares the sample in that same falling-edge half-cycle.

The expected phase and gain are stepped once per strobe, using the R2, R4, R7 and R8 rules. Phase continuity across tone changes and the shape of the fade are both checked sample by sample.

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
  parameter int CLK_HZ     = 3579545,
  parameter int SAMPLE_DIV = 466,
  parameter int PHASE_W    = 24,
  parameter int OUT_W      = 12,
  parameter int LUT_AW     = 6,
  parameter int RAMP_W     = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tx_data,
  input  logic                    orig_sel,
  input  logic                    bell_sel,
  input  logic                    tx_en_n,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sample_stb
);

  localparam int CNT_W     = $clog2(SAMPLE_DIV);
  localparam int AMAX      = 2**(OUT_W-1) - 1;
  localparam int LUT_N     = 2**LUT_AW;
  localparam int IDX_W     = LUT_AW + 2;
  localparam int GAIN_W    = RAMP_W + 1;
  localparam int GAIN_FULL = 2**RAMP_W;
  localparam int PROD_W    = OUT_W - 1 + RAMP_W;

  function automatic logic [PHASE_W-1:0] step_of(input int hz);
    longint num;
    num = longint'(hz) * (longint'(1) << PHASE_W) * longint'(SAMPLE_DIV);
    return PHASE_W'((num + longint'(CLK_HZ / 2)) / longint'(CLK_HZ));
  endfunction

  localparam logic [PHASE_W-1:0] STEP [8] = '{
    step_of(1850), step_of(1650), step_of(1180), step_of(980),
    step_of(2025), step_of(2225), step_of(1070), step_of(1270)
  };

  logic [3:0]          sync1, sync2;
  logic [CNT_W-1:0]    cnt;
  logic [PHASE_W-1:0]  phase;
  logic [GAIN_W-1:0]   gain;
  logic [OUT_W-2:0]    lut [LUT_N];

  wire                 tick  = (cnt == CNT_W'(SAMPLE_DIV - 1));
  wire                 en    = sync2[0];
  wire [PHASE_W-1:0]   inc   = STEP[sync2[3:1]];
  wire [IDX_W-1:0]     k     = phase[PHASE_W-1 -: IDX_W];
  wire [LUT_AW-1:0]    addr  = k[IDX_W-2] ? ~k[LUT_AW-1:0] : k[LUT_AW-1:0];
  wire [OUT_W-2:0]     mag   = lut[addr];
  wire [PROD_W-1:0]    prod  = mag * gain;
  wire [OUT_W-2:0]     scl   = prod[PROD_W-1:RAMP_W];
  wire signed [OUT_W-1:0] pos = $signed({1'b0, scl});

  for (genvar i = 0; i < LUT_N; i++) begin : g_lut
    localparam real ANG = 6.283185307179586 * (real'(i) + 0.5) / real'(4 * LUT_N);
    assign lut[i] = (OUT_W-1)'($rtoi(real'(AMAX) * $sin(ANG) + 0.5));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {bell_sel, orig_sel, tx_data, ~tx_en_n};
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= '0;
      gain       <= '0;
      sample     <= '0;
      sample_stb <= 1'b0;
    end else begin
      sample_stb <= tick;
      if (tick) begin
        sample <= k[IDX_W-1] ? -pos : pos;
        if (en) begin
          gain  <= GAIN_W'(GAIN_FULL);
          phase <= phase + inc;
        end else if (gain != '0) begin
          gain  <= gain - 1'b1;
          phase <= phase + inc;
        end else begin
          phase <= '0;
        end
      end
    end
  end

  a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  a_r4_sample_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (sample <= AMAX && sample >= -AMAX));

  a_r5_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));

  a_r6_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !en && gain == '0) |=> (sample == '0 && phase == '0));

  a_r7_fade_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !en && gain != '0) |=> (gain < $past(gain)));

  a_r8_full_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en) |=> (gain == GAIN_W'(GAIN_FULL)));

endmodule

// File: tb/test_fsk_tone_gen.sv
`timescale 1ns/1ps
module test_fsk_tone_gen;
  localparam int  DIV    = 466;
  localparam int  CLK_HZ = 3579545;
  localparam longint MASK = (longint'(1) << 24) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_data = 1'b1, orig_sel = 1'b1, bell_sel = 1'b0, tx_en_n = 1'b1;
  logic signed [11:0] sample;
  logic sample_stb;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  longint ph = 0;
  int g = 0;

  localparam logic [2:0] VEC [8] = '{3'b011, 3'b010, 3'b001, 3'b000,
                                    3'b111, 3'b110, 3'b101, 3'b100};

  fsk_tone_gen i_fsk_tone_gen (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .orig_sel(orig_sel),
    .bell_sel(bell_sel), .tx_en_n(tx_en_n), .sample(sample), .sample_stb(sample_stb));

  always #5 clk = ~clk;

  function automatic int tone_hz(input bit b, input bit o, input bit d);
    case ({b, o, d})
      3'b011: return 980;  3'b010: return 1180;
      3'b001: return 1650; 3'b000: return 1850;
      3'b111: return 1270; 3'b110: return 1070;
      3'b101: return 2225; default: return 2025;
    endcase
  endfunction

  function automatic longint step_of(input int hz);
    return (longint'(hz) * (longint'(1) << 24) * DIV + CLK_HZ / 2) / CLK_HZ;
  endfunction

  function automatic int model_out();
    int k, m, v;
    real s;
    k = int'(ph >> 16);
    s = $sin(6.283185307179586 * (real'(k) + 0.5) / 256.0);
    m = $rtoi(2047.0 * (s < 0.0 ? -s : s) + 0.5);
    v = (m * g) >>> 6;
    return (s < 0.0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input string req, output int gap);
    int exp, act;
    gap = 0;
    do begin @(negedge clk); gap++; end while (!sample_stb);
    exp = model_out();
    act = int'(sample);
    check((act - exp <= 1) && (exp - act <= 1), req, act, exp);
    if (!tx_en_n) begin
      g = 64;
      ph = (ph + step_of(tone_hz(bell_sel, orig_sel, tx_data))) & MASK;
    end else if (g > 0) begin
      g--;
      ph = (ph + step_of(tone_hz(bell_sel, orig_sel, tx_data))) & MASK;
    end else begin
      ph = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int gap;
    repeat (4) @(negedge clk);
    check(sample == 0, "R9 sample in reset", int'(sample), 0);
    check(sample_stb == 0, "R9 strobe in reset", int'(sample_stb), 0);
    rst_n = 1'b1;

    step("R6 idle after reset", gap);
    for (int i = 0; i < 3; i++) begin
      step("R6 idle", gap);
      check(gap == DIV, "R1 strobe spacing", gap, DIV);
    end

    tx_en_n = 1'b0;
    step("R8 first enabled strobe", gap);
    for (int v = 0; v < 8; v++) begin
      {bell_sel, orig_sel, tx_data} = VEC[v];
      for (int n = 0; n < 14; n++) step("R2 R3 R4 R5 tone vector", gap);
    end

    bell_sel = 1'b0; orig_sel = 1'b0; tx_data = 1'b1;
    for (int n = 0; n < 6; n++) step("R5 answer mark", gap);
    tx_en_n = 1'b1;
    for (int n = 0; n < 66; n++) step("R7 fade", gap);
    for (int n = 0; n < 3; n++) begin
      step("R6 silent after fade", gap);
      check(sample == 0, "R6 zero output", int'(sample), 0);
    end

    orig_sel = 1'b1; tx_data = 1'b0;
    tx_en_n = 1'b0;
    for (int n = 0; n < 8; n++) step("R6 R8 restart from zero phase", gap);
    tx_en_n = 1'b1;
    for (int n = 0; n < 10; n++) step("R7 partial fade", gap);
    tx_en_n = 1'b0;
    for (int n = 0; n < 5; n++) step("R8 resume at full gain", gap);
    tx_data = 1'b1;
    for (int n = 0; n < 4; n++) begin
      step("R1 R5 mark after resume", gap);
      check(gap == DIV, "R1 strobe spacing", gap, DIV);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule